// File: doc/BRIEF.md
# SD Host Event Status and Interrupt Register

This block keeps the event state of an SD/MMC host controller in one 32-bit status word and turns it into one level-sensitive interrupt line. The command, data and card-detect engines around it report each event as a one-cycle pulse on a 32-bit event vector. The pulse sits at the same bit position the event takes in the status word. Pulses at sticky positions set flags, and each flag stays set until software writes a one to it. Some status positions do not hold flags. They show buffer readiness and buffer-half fill state as live levels from the data path. Bits 10:9 hold the last two-bit write-CRC status token that the card returned.

A 16-bit interrupt enable register selects which done and card events drive the interrupt. The interrupt output is a flop. It rises one clock after an enabled flag becomes set and falls one clock after the last enabled flag clears. Both registers sit on a small port with an address, a write strobe, write data and combinational read data.

Top module: `sdhost_evt_status`

## Requirements
- R1: While reset is held, the status word reads 0 (with all level inputs low), the enable register reads 0 and `irq` is low.
- R2: A pulse at a sticky position sets that status bit at the next clock edge, and the bit stays set with no further pulse. The sticky positions are 31 (card inserted), 30 (card removed), 14 (SDIO interrupt), 13 (command response ended), 12 (write done), 11 (read/data done), 5, 3, 2, 1 and 0.
- R3: A write to address 0 clears every sticky bit that has a one in the write data. Sticky bits with a zero in the write data keep their value.
- R4: When a set pulse and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R5: Bits 29/28 show buffer halves 1/0 empty, bits 27/26 show halves 1/0 full, bit 7 shows read-ready and bit 6 shows write-ready. Each of these bits follows its input in the same cycle. Writes to these bits have no effect, and pulses at these positions have no effect.
- R6: The error group under mask 0x2F is sticky and write-one-to-clear. Bit 5 is response CRC, bit 3 read CRC, bit 2 write CRC, bit 1 response timeout and bit 0 read timeout. No error bit drives `irq`.
- R7: Bits 10:9 take `crc_tok` at the edge where `crc_tok_vld` is high, and hold their value otherwise. A write does not change them. Code 2 means the card returned no CRC status.
- R8: The enable register is at address 1. Bits 0, 1, 2, 13, 14 and 15 store the written value. All other bits read 0.
- R9: `irq` is a register. It is high in the cycle after any of these pairs is set in both registers: enable 0 with status 11, enable 1 with status 12, enable 2 with status 13, enable 13 with status 14, enable 14 with status 30, enable 15 with status 31. Otherwise it is low.
- R10: Status bits 8 and 25..15 always read 0, and pulses at these positions have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address: 0 status, 1 enable |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| evt_pulse | input | 32 | One-cycle event pulses, aligned to status positions |
| buf_rd_rdy | input | 1 | Buffer ready for read (level) |
| buf_wr_rdy | input | 1 | Buffer ready for write (level) |
| half_empty | input | 2 | Per buffer half: empty (level) |
| half_full | input | 2 | Per buffer half: full (level) |
| crc_tok_vld | input | 1 | Write-CRC token strobe |
| crc_tok | input | 2 | Write-CRC token code |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a set pulse and a write-one-to-clear landing on the same bit in the same clock. Only that case shows whether the set takes priority, and it needs the engine side and the bus side driven in the same cycle. The vector table puts the event pulse and the status write into one entry, so both are applied at a single edge. The interrupt timing is checked one cycle at a time around setting and clearing a flag. That check shows the one-cycle lag of the registered `irq` on both edges.

// File: rtl/sdhost_evt_pkg.sv
package sdhost_evt_pkg;
  localparam int STAT_W = 32;
  localparam int IEN_W  = 16;

  // positions that hold write-one-to-clear flags
  localparam logic [STAT_W-1:0] STICKY_MASK = 32'hC000_782F;
  // positions that mirror live levels
  localparam logic [STAT_W-1:0] LEVEL_MASK  = 32'h3C00_00C0;
  // writable interrupt enable bits
  localparam logic [IEN_W-1:0]  IEN_MASK    = 16'hE007;

  localparam int TOK_LSB = 9;
  localparam int TOK_W   = 2;

  // aligns interrupt-capable status flags to their enable positions
  function automatic logic [IEN_W-1:0] irq_sources(input logic [STAT_W-1:0] st);
    logic [IEN_W-1:0] s;
    s     = '0;
    s[0]  = st[11];
    s[1]  = st[12];
    s[2]  = st[13];
    s[13] = st[14];
    s[14] = st[30];
    s[15] = st[31];
    return s;
  endfunction
endpackage

// File: rtl/evt_sticky_bank.sv
module evt_sticky_bank #(
  parameter int                W    = 32,
  parameter logic [W-1:0]      MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;
  logic         unused_nonsticky;

  always_comb begin
    nxt = (q_o & ~clr_i) | set_i;  // set beats clear
  end

  assign unused_nonsticky = ^{set_i & ~MASK, clr_i & ~MASK};

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_flag
      logic en;
      assign en = set_i[i] | clr_i[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q_o[i] <= 1'b0;
        else if (en) q_o[i] <= nxt[i];
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> q_o[i]);  // R4
      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !set_i[i]) |=> !q_o[i]);  // R3
      AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i[i] && !set_i[i]) |=> $stable(q_o[i]));  // R2
    end else begin : g_none
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/evt_crc_token.sv
module evt_crc_token #(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [TW-1:0] tok_i,
  output logic [TW-1:0] tok_o
);
  logic [TW-1:0] tok_nxt;

  always_comb begin
    tok_nxt = tok_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tok_o <= '0;
    else if (vld_i) tok_o <= tok_nxt;
  end

  AST_TOK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(tok_o));  // R7
  AST_TOK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> (tok_o == $past(tok_i)));  // R7
endmodule

// File: rtl/evt_irq_reg.sv
module evt_irq_reg #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ien_i,
  input  logic [N-1:0] src_i,
  output logic         irq_o
);
  logic pend;

  always_comb begin
    pend = |(ien_i & src_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pend;
  end

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ien_i & src_i)) |=> irq_o);  // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(ien_i & src_i)) |=> !irq_o);  // R9
endmodule

// File: rtl/sdhost_evt_status.sv
module sdhost_evt_status
  import sdhost_evt_pkg::*;
#(
  parameter int                ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 0,
  parameter logic [ADDR_W-1:0] IEN_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       evt_pulse,
  input  logic              buf_rd_rdy,
  input  logic              buf_wr_rdy,
  input  logic [1:0]        half_empty,
  input  logic [1:0]        half_full,
  input  logic              crc_tok_vld,
  input  logic [1:0]        crc_tok,
  output logic              irq
);
  logic              wr_stat, wr_ien;
  logic [STAT_W-1:0] set_v, clr_v, flags, level_v, tok_v, stat_word;
  logic [TOK_W-1:0]  tok_q;
  logic [IEN_W-1:0]  ien_q, ien_nxt, src_v;
  logic              unused_wbits;

  always_comb begin
    wr_stat = bus_wr_en && (bus_addr == STAT_ADDR);
    wr_ien  = bus_wr_en && (bus_addr == IEN_ADDR);
    set_v   = evt_pulse & STICKY_MASK;
    clr_v   = wr_stat ? (bus_wdata & STICKY_MASK) : '0;
  end

  evt_sticky_bank #(.W(STAT_W), .MASK(STICKY_MASK)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(set_v),
    .clr_i(clr_v),
    .q_o  (flags)
  );

  evt_crc_token #(.TW(TOK_W)) u_tok (
    .clk  (clk),
    .rst_n(rst_n),
    .vld_i(crc_tok_vld),
    .tok_i(crc_tok),
    .tok_o(tok_q)
  );

  // enable register: next-state and register kept apart
  always_comb begin
    ien_nxt = bus_wdata[IEN_W-1:0] & IEN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (wr_ien) ien_q <= ien_nxt;
  end

  assign unused_wbits = ^bus_wdata[STAT_W-1:IEN_W];

  always_comb begin
    level_v       = '0;
    level_v[29]   = half_empty[1];
    level_v[28]   = half_empty[0];
    level_v[27]   = half_full[1];
    level_v[26]   = half_full[0];
    level_v[7]    = buf_rd_rdy;
    level_v[6]    = buf_wr_rdy;
    tok_v         = '0;
    tok_v[TOK_LSB +: TOK_W] = tok_q;
    stat_word     = flags | level_v | tok_v;
    src_v         = irq_sources(flags);
  end

  evt_irq_reg #(.N(IEN_W)) u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .ien_i(ien_q),
    .src_i(src_v),
    .irq_o(irq)
  );

  always_comb begin
    if (bus_addr == STAT_ADDR)     bus_rdata = stat_word;
    else if (bus_addr == IEN_ADDR) bus_rdata = {{(STAT_W-IEN_W){1'b0}}, ien_q};
    else                           bus_rdata = '0;
  end

  AST_IEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ien |=> (ien_q == ($past(bus_wdata[IEN_W-1:0]) & IEN_MASK)));  // R8
  AST_IEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ien |=> $stable(ien_q));  // R8
  AST_ERR_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_v & ien_q) == '0) |=> !irq);  // R6
endmodule

// File: tb/sdhost_evt_status_tb_top.sv
module sdhost_evt_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic        bus_wr_en;
  logic [31:0] bus_wdata, bus_rdata, evt_pulse;
  logic        buf_rd_rdy, buf_wr_rdy, crc_tok_vld, irq;
  logic [1:0]  half_empty, half_full, crc_tok;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  sdhost_evt_status dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .buf_rd_rdy(buf_rd_rdy), .buf_wr_rdy(buf_wr_rdy), .half_empty(half_empty),
    .half_full(half_full), .crc_tok_vld(crc_tok_vld), .crc_tok(crc_tok), .irq(irq)
  );

  // {event pulse, write strobe, write data, expected status}
  localparam logic [96:0] VEC [8] = '{
    {32'h0000_2000, 1'b0, 32'h0000_0000, 32'h0000_2000},
    {32'h8000_0001, 1'b0, 32'h0000_0000, 32'h8000_2001},
    {32'h0000_0000, 1'b1, 32'h0000_2000, 32'h8000_0001},
    {32'h0400_0100, 1'b0, 32'h0000_0000, 32'h8000_0001},
    {32'h0000_0000, 1'b1, 32'h0000_0000, 32'h8000_0001},
    {32'h0000_002E, 1'b1, 32'h0000_0001, 32'h8000_002E},
    {32'h0000_0004, 1'b1, 32'h0000_0004, 32'h8000_002E},
    {32'h0000_0000, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic idle();
    bus_wr_en = 1'b0; bus_wdata = '0; evt_pulse = '0; crc_tok_vld = 1'b0;
  endtask

  // called at a falling edge; applies inputs across one rising edge
  task automatic step(input logic [31:0] ev, input logic we,
                      input logic [1:0] a, input logic [31:0] wd);
    evt_pulse = ev; bus_wr_en = we; bus_addr = a; bus_wdata = wd;
    @(posedge clk); #1;
    idle();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog got=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; idle(); bus_addr = '0;
    buf_rd_rdy = 0; buf_wr_rdy = 0; half_empty = 0; half_full = 0; crc_tok = 0;
    repeat (3) @(negedge clk);
    rd(2'd0, d); chk("R1 status in reset", d, 32'h0);
    rd(2'd1, d); chk("R1 enable in reset", d, 32'h0);
    chk("R1 irq in reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: R2 set, R3 clear, R4 set wins, R6 errors, R10 unused/level ignored
    for (int i = 0; i < 8; i++) begin
      step(VEC[i][96:65], VEC[i][64], 2'd0, VEC[i][63:32]);
      rd(2'd0, d);
      chk($sformatf("R2/R3/R4/R6/R10 vector %0d", i), d, VEC[i][31:0]);
    end

    // R5 level bits follow inputs and ignore writes and pulses
    half_empty = 2'b10; half_full = 2'b01; buf_rd_rdy = 1; buf_wr_rdy = 0;
    rd(2'd0, d); chk("R5 levels mirror", d, 32'h2400_0080);
    step(32'h0, 1'b1, 2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R5 levels ignore write", d, 32'h2400_0080);
    step(32'h1800_0040, 1'b0, 2'd0, 32'h0);
    rd(2'd0, d); chk("R5 levels ignore pulses", d, 32'h2400_0080);
    half_empty = 0; half_full = 0; buf_rd_rdy = 0;
    rd(2'd0, d); chk("R5 levels drop", d, 32'h0);

    // R10 unused positions
    step(32'h03FF_8100, 1'b0, 2'd0, 32'h0);
    rd(2'd0, d); chk("R10 unused bits stay 0", d, 32'h0);

    // R7 write-CRC token
    crc_tok = 2'd2; crc_tok_vld = 1'b1;
    @(posedge clk); #1; crc_tok_vld = 1'b0; @(negedge clk);
    rd(2'd0, d); chk("R7 token latched no-CRC code", d, 32'h0000_0400);
    step(32'h0, 1'b1, 2'd0, 32'h0000_0600);
    rd(2'd0, d); chk("R7 token ignores write", d, 32'h0000_0400);
    crc_tok = 2'd1;
    step(32'h0, 1'b0, 2'd0, 32'h0);
    rd(2'd0, d); chk("R7 token holds without strobe", d, 32'h0000_0400);
    crc_tok_vld = 1'b1;
    @(posedge clk); #1; crc_tok_vld = 1'b0; @(negedge clk);
    rd(2'd0, d); chk("R7 token updates", d, 32'h0000_0200);

    // R8 enable register
    step(32'h0, 1'b1, 2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R8 enable writable bits", d, 32'h0000_E007);

    // R6 errors never interrupt, even with all enables on
    step(32'h0000_002F, 1'b0, 2'd0, 32'h0);
    @(negedge clk);
    chk("R6 errors raise no irq", {31'b0, irq}, 32'h0);
    step(32'h0, 1'b1, 2'd0, 32'h0000_002F);

    // R9 irq timing with only end-of-response enabled
    step(32'h0, 1'b1, 2'd1, 32'h0000_0004);
    step(32'h0000_1000, 1'b0, 2'd0, 32'h0);
    @(negedge clk);
    chk("R9 unenabled flag no irq", {31'b0, irq}, 32'h0);
    step(32'h0000_2000, 1'b0, 2'd0, 32'h0);
    chk("R9 irq lags flag by one clock", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq asserted", {31'b0, irq}, 32'h1);
    step(32'h0, 1'b1, 2'd0, 32'h0000_2000);
    chk("R9 irq still high one clock after clear", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R9 irq drops", {31'b0, irq}, 32'h0);

    // R9 card insertion mapping (enable 15 to status 31)
    step(32'h0, 1'b1, 2'd1, 32'h0000_8000);
    step(32'h8000_0000, 1'b0, 2'd0, 32'h0);
    @(negedge clk);
    chk("R9 insertion irq", {31'b0, irq}, 32'h1);
    step(32'h0, 1'b1, 2'd1, 32'h0);
    @(negedge clk);
    chk("R9 irq off when enable cleared", {31'b0, irq}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule